// File: doc/BRIEF.md
# Serial Host Register Port

This block is a slave port for a serial host link. It gives a host controller write and read access to a small bank of 8-bit control registers and one read-only status byte. Each transfer is framed by an active-low chip select. It carries two bytes, each shifted least significant bit first: a command byte that holds a direction flag and a 7-bit register address, then one data byte. The host clock is oversampled by the block's own clock, so the port runs independently of any line timing. A select input sets the host clock edge on which read data is launched.

The serial output drives only while read data is being returned. At all other times it is released (high impedance), so the serial input and output can share one wire. An output-enable port mirrors the drive state. One bit of control register 1 is brought out separately as the remote-loopback request.

Top module: `hs_serial_regport`

## Requirements
- R1: A transfer starts only when chip select is seen going from high to low. If chip select is already low when reset ends, host clock edges are ignored until it has been high once.
- R2: On the host clock rising edges 1 to 8 the command byte is sampled, LSB first: bit 0 is the direction (1 = read, 0 = write) and bits 7:1 are the address. On rising edges 9 to 16 the write data is sampled, LSB first.
- R3: A write updates the addressed register only after the 16th rising edge, and only if chip select stayed low up to that edge. If chip select is raised earlier, every register keeps its value.
- R4: With the edge select at 1, read bit D(n) is launched after rising edge 8+n (n = 0..7). D7 stays driven until the falling edge that follows rising edge 16, and the output is then released.
- R5: With the edge select at 0, read bit D(n) is launched at the falling edge that follows rising edge 8+n. D7 stays driven until rising edge 17, and the output is then released.
- R6: Raising chip select releases the serial output at once, without waiting for the block clock, including in the middle of a read data phase.
- R7: The output is released while idle, during the command byte, and for the whole of a write transfer.
- R8: Addresses 0 to NREG-1 are read/write registers. Address STAT_ADDR (default 0x10) returns the status input and ignores writes. Any other address reads 0 and ignores writes.
- R9: `rloop_o` equals bit 5 of register 1.
- R10: After reset every register is 0 and the output is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the host link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| sdi | input | 1 | Serial data from host |
| clke | input | 1 | Read launch edge select: 1 = rising, 0 = falling |
| sdo | output | 1 | Serial read data; high impedance when not driving |
| sdo_oe | output | 1 | High while sdo is driven |
| status_i | input | 8 | Status byte returned at STAT_ADDR |
| ctrl_o | output | NREG*8 | All control registers, register i in bits 8i+7:8i |
| rloop_o | output | 1 | Remote-loopback request (register 1, bit 5) |

## Verification
A bit counter that is off by one shows up within the same transfer. Read data is shifted by one position, or the output is still driven, or already released, one edge away from the expected point. A wrong latched direction flag shows up as driving during a write, or as a register changing after a read. Both are visible on `sdo_oe` or `ctrl_o` within a few block clocks of the host edge concerned. A write path that fails to stop on an early chip-select release leaves a modified register, and the next readback or `ctrl_o` sample exposes it.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int CNT_W      = 5;
    localparam int CMD_BITS   = 8;   // rising edges carrying the command byte
    localparam int FRAME_BITS = 16;  // rising edges carrying both bytes
    localparam int END_EDGE   = 17;  // last counted rising edge

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       cmd;
        logic [7:0]       wdat;
        logic [7:0]       rsh;
        logic             drv;
        logic             sdo_bit;
        logic             we;
    } frame_st_t;
endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_low_o,
    output logic cs_fall_o,
    output logic sdi_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] stg_d [STAGES];
    logic [NSIG-1:0] stg_q [STAGES];
    logic [NSIG-1:0] prev_d, prev_q;
    logic [NSIG-1:0] cur;

    always_comb begin
        stg_d[0] = {sdi_i, cs_n_i, sclk_i};
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
        prev_d = stg_q[STAGES-1];
    end

    // reset value 0 makes chip select look low, so a high level must be seen first
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign cur         = stg_q[STAGES-1];
    assign sclk_rise_o = cur[0] & ~prev_q[0];
    assign sclk_fall_o = ~cur[0] & prev_q[0];
    assign cs_low_o    = ~cur[1];
    assign cs_fall_o   = ~cur[1] & prev_q[1];
    assign sdi_o       = cur[2];
endmodule

// File: rtl/hs_frame_ctl.sv
module hs_frame_ctl
    import hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       cs_low_i,
    input  logic       cs_fall_i,
    input  logic       sdi_i,
    input  logic       clke_i,
    input  logic [7:0] rd_data_i,
    output logic [6:0] rd_addr_o,
    output logic       we_o,
    output logic [6:0] waddr_o,
    output logic [7:0] wdata_o,
    output logic       drv_o,
    output logic       sdo_bit_o
);
    frame_st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             rd_at_8;

    assign cnt_inc   = st_q.cnt + CNT_W'(1);
    // address and direction as they stand once the 8th command bit is in
    assign rd_addr_o = {sdi_i, st_q.cmd[7:2]};
    assign rd_at_8   = st_q.cmd[1];

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (!cs_low_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.drv    = 1'b0;
        end else if (cs_fall_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.drv    = 1'b0;
        end else if (st_q.active) begin
            if (rise_i && st_q.cnt < CNT_W'(END_EDGE)) begin
                st_d.cnt = cnt_inc;
                if (st_q.cnt < CNT_W'(CMD_BITS)) begin
                    st_d.cmd = {sdi_i, st_q.cmd[7:1]};
                end else if (st_q.cnt < CNT_W'(FRAME_BITS) && !st_q.cmd[0]) begin
                    st_d.wdat = {sdi_i, st_q.wdat[7:1]};
                end
                if (cnt_inc == CNT_W'(CMD_BITS)) begin
                    if (rd_at_8) begin
                        st_d.rsh = rd_data_i;
                        if (clke_i) begin
                            st_d.sdo_bit = rd_data_i[0];
                            st_d.rsh     = {1'b0, rd_data_i[7:1]};
                            st_d.drv     = 1'b1;
                        end
                    end
                end else if (st_q.cmd[0]) begin
                    if (clke_i && cnt_inc < CNT_W'(FRAME_BITS)) begin
                        st_d.sdo_bit = st_q.rsh[0];
                        st_d.rsh     = {1'b0, st_q.rsh[7:1]};
                    end else if (!clke_i && cnt_inc == CNT_W'(END_EDGE)) begin
                        st_d.drv = 1'b0;
                    end
                end else if (cnt_inc == CNT_W'(FRAME_BITS)) begin
                    st_d.we = 1'b1;
                end
            end
            if (fall_i && st_q.cmd[0]) begin
                if (!clke_i && st_q.cnt >= CNT_W'(CMD_BITS) && st_q.cnt < CNT_W'(FRAME_BITS)) begin
                    st_d.sdo_bit = st_q.rsh[0];
                    st_d.rsh     = {1'b0, st_q.rsh[7:1]};
                    st_d.drv     = 1'b1;
                end else if (clke_i && st_q.cnt == CNT_W'(FRAME_BITS)) begin
                    st_d.drv = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we_o      = st_q.we;
    assign waddr_o   = st_q.cmd[7:1];
    assign wdata_o   = st_q.wdat;
    assign drv_o     = st_q.drv;
    assign sdo_bit_o = st_q.sdo_bit;

    // R7
    drv_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drv |-> (st_q.active && st_q.cmd[0] && st_q.cnt >= CNT_W'(CMD_BITS)));

    // R6
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low_i |=> !st_q.drv);

    // R3
    wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> (st_q.cnt == CNT_W'(FRAME_BITS) && !st_q.cmd[0] && st_q.active));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && cs_low_i && !cs_fall_i && rise_i && st_q.cnt < CNT_W'(END_EDGE))
        |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/hs_reg_bank.sv
module hs_reg_bank #(
    parameter int         NREG      = 4,
    parameter logic [6:0] STAT_ADDR = 7'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [6:0]        waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [6:0]        rd_addr_i,
    input  logic [7:0]        status_i,
    output logic [7:0]        rd_data_o,
    output logic [NREG*8-1:0] ctrl_o
);
    localparam int FLAT_W = NREG * 8;

    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (we_i && waddr_i == 7'(i)) regs_d[i] = wdata_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == STAT_ADDR) rd_data_o = status_i;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr_i == 7'(i)) rd_data_o = regs_q[i];
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) regs_q[g] <= '0;
                else        regs_q[g] <= regs_d[g];
            end
            assign ctrl_o[g*8 +: 8] = regs_q[g];
        end
    endgenerate

    // R3
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctrl_o));

    // R8
    ro_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i >= 7'(NREG)) |=> $stable(ctrl_o));

    initial begin
        // R8
        stat_map_chk: assert (int'(STAT_ADDR) >= NREG && FLAT_W > 0);
    end
endmodule

// File: rtl/hs_serial_regport.sv
module hs_serial_regport #(
    parameter int         NREG        = 4,
    parameter logic [6:0] STAT_ADDR   = 7'h10,
    parameter int         SYNC_STAGES = 2,
    parameter int         RLOOP_REG   = 1,
    parameter int         RLOOP_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              clke,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [7:0]        status_i,
    output logic [NREG*8-1:0] ctrl_o,
    output logic              rloop_o
);
    localparam int RLOOP_POS = RLOOP_REG * 8 + RLOOP_BIT;

    logic       rise, fall, cs_low, cs_fall, sdi_s;
    logic [6:0] rd_addr, waddr;
    logic [7:0] rd_data, wdata;
    logic       we, drv, sdo_bit;

    hs_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .cs_n_i     (cs_n),
        .sdi_i      (sdi),
        .sclk_rise_o(rise),
        .sclk_fall_o(fall),
        .cs_low_o   (cs_low),
        .cs_fall_o  (cs_fall),
        .sdi_o      (sdi_s)
    );

    hs_frame_ctl frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .fall_i   (fall),
        .cs_low_i (cs_low),
        .cs_fall_i(cs_fall),
        .sdi_i    (sdi_s),
        .clke_i   (clke),
        .rd_data_i(rd_data),
        .rd_addr_o(rd_addr),
        .we_o     (we),
        .waddr_o  (waddr),
        .wdata_o  (wdata),
        .drv_o    (drv),
        .sdo_bit_o(sdo_bit)
    );

    hs_reg_bank #(.NREG(NREG), .STAT_ADDR(STAT_ADDR)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (we),
        .waddr_i  (waddr),
        .wdata_i  (wdata),
        .rd_addr_i(rd_addr),
        .status_i (status_i),
        .rd_data_o(rd_data),
        .ctrl_o   (ctrl_o)
    );

    // release follows the raw chip-select pin, not the synchronised copy
    assign sdo_oe  = drv & ~cs_n;
    assign sdo     = sdo_oe ? sdo_bit : 1'bz;
    assign rloop_o = ctrl_o[RLOOP_POS];

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_o == '0));
endmodule

// File: tb/hs_serial_regport_tb_top.sv
`timescale 1ns/1ps
module hs_serial_regport_tb_top;
    localparam int         NREG = 4;
    localparam logic [6:0] STAT = 7'h10;
    localparam int         H    = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b0, sdi = 1'b0, clke = 1'b1;
    logic [7:0] status = 8'h3C;
    wire  sdo, sdo_oe, rloop;
    wire  [NREG*8-1:0] ctrl;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mreg [NREG];

    always #2 clk = ~clk;

    hs_serial_regport dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .clke(clke), .sdo(sdo), .sdo_oe(sdo_oe), .status_i(status),
        .ctrl_o(ctrl), .rloop_o(rloop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] model_read(input logic [6:0] a);
        if (a == STAT) return status;
        if (int'(a) < NREG) return mreg[a];
        return 8'h00;
    endfunction

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mreg[i];
        return f;
    endfunction

    // index of the read bit expected on sdo at the end of a phase, -1 when released
    function automatic int exp_idx(input bit rd, input bit ck, input int k, input bit high);
        if (!rd) return -1;
        if (!high) begin
            if (k >= 9 && k <= 16) return k - 9;
            if (k == 17 && !ck) return 7;
            return -1;
        end
        if (ck) return (k >= 8 && k <= 16) ? ((k == 16) ? 7 : k - 8) : -1;
        return (k >= 9 && k <= 16) ? k - 9 : -1;
    endfunction

    task automatic phase_chk(input bit rd, input bit ck, input int k, input bit high, input logic [7:0] expd);
        int idx = exp_idx(rd, ck, k, high);
        string req = !rd ? "R7 write hi-z" : (idx < 0 ? "R7 read hi-z" : (ck ? "R4 rising launch" : "R5 falling launch"));
        if (idx < 0) chk(req, 32'(sdo_oe), 32'd0);
        else begin
            chk(req, 32'(sdo_oe), 32'd1);
            chk(req, 32'(sdo), 32'(expd[idx]));
        end
    endtask

    task automatic xfer(input bit rd, input logic [6:0] a, input logic [7:0] wd,
                        input bit ck, input int nrise);
        logic [7:0] cmdb = {a, rd};
        logic [7:0] expd = model_read(a);
        clke = ck;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(H);
        for (int k = 1; k <= nrise; k++) begin
            sdi = (k <= 8) ? cmdb[k-1] : ((k <= 16) ? wd[k-9] : 1'b0);
            wait_clk(H);
            phase_chk(rd, ck, k, 1'b0, expd);
            sclk = 1'b1;
            wait_clk(H);
            phase_chk(rd, ck, k, 1'b1, expd);
            if (k == nrise && nrise < 16) begin
                cs_n = 1'b1;   // early release with sclk still high
                #1;
                chk("R6 release on cs high", 32'(sdo_oe), 32'd0);
            end
            sclk = 1'b0;
        end
        wait_clk(H);
        if (nrise >= 16) chk("R4 R5 end of hold", 32'(sdo_oe), 32'(ck ? 1'b0 : 1'b0));
        cs_n = 1'b1;
        wait_clk(H);
        chk("R7 idle hi-z", 32'(sdo_oe), 32'd0);
        if (!rd && nrise >= 16 && int'(a) < NREG) mreg[a] = wd;
        chk("R3 register image", ctrl, model_flat());
        chk("R9 remote loopback bit", 32'(rloop), 32'(mreg[1][5]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R10 reset state
        chk("R10 reset registers", ctrl, '0);
        chk("R10 reset hi-z", 32'(sdo_oe), 32'd0);

        // R1 chip select low since reset: a full write frame must be ignored
        for (int k = 1; k <= 16; k++) begin
            sdi = (k <= 8) ? ((k == 1) ? 1'b0 : 1'b0) : 1'b1;
            wait_clk(H); sclk = 1'b1; wait_clk(H); sclk = 1'b0;
        end
        wait_clk(H);
        chk("R1 no frame without cs high first", ctrl, '0);
        chk("R1 no drive", 32'(sdo_oe), 32'd0);
        cs_n = 1'b1;
        wait_clk(H);

        // directed: R2 R9 write register 1 bit 5, read back with both edges
        xfer(1'b0, 7'd1, 8'h20, 1'b1, 16);
        chk("R9 rloop set", 32'(rloop), 32'd1);
        xfer(1'b1, 7'd1, 8'h00, 1'b1, 17);
        xfer(1'b1, 7'd1, 8'h00, 1'b0, 17);
        xfer(1'b0, 7'd3, 8'hA5, 1'b0, 16);
        xfer(1'b1, 7'd3, 8'h00, 1'b1, 17);
        xfer(1'b1, 7'd3, 8'h00, 1'b0, 17);
        // R8 status address read-only, unmapped reads zero
        xfer(1'b0, STAT, 8'hFF, 1'b1, 16);
        xfer(1'b1, STAT, 8'h00, 1'b0, 17);
        xfer(1'b0, 7'h55, 8'h77, 1'b0, 16);
        xfer(1'b1, 7'h55, 8'h00, 1'b1, 17);
        // R3 aborted write, R6 aborted read
        xfer(1'b0, 7'd0, 8'hC3, 1'b1, 12);
        xfer(1'b1, 7'd0, 8'h00, 1'b1, 17);
        xfer(1'b1, 7'd3, 8'h00, 1'b1, 11);
        xfer(1'b1, 7'd3, 8'h00, 1'b0, 13);
        // R9 clear the loopback bit
        xfer(1'b0, 7'd1, 8'hDF, 1'b0, 16);

        for (int t = 0; t < 40; t++) begin
            int sel = int'($urandom % 4);
            logic [6:0] a;
            int nr;
            bit rd = bit'($urandom % 2);
            bit ck = bit'($urandom % 2);
            if (sel < 2)       a = 7'($urandom % NREG);
            else if (sel == 2) a = STAT;
            else               a = 7'($urandom);
            nr = rd ? 17 : 16;
            if ($urandom % 8 == 0) nr = 9 + int'($urandom % 6);
            status = 8'($urandom);
            xfer(rd, a, 8'($urandom), ck, nr);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule